// File: doc/BRIEF.md
# I2C Slave Event Status and Interrupt Control

This block is the register-side companion of an I2C slave bit engine. The engine reports bus and transfer events as one-cycle pulses. The block turns them into a 3-bit code that records the most recent event. It holds received bytes in a small buffer for the CPU to read. It keeps two sticky flags, operation-complete and receive-overrun, and each flag has its own enable bit. Together they drive one level-sensitive interrupt request.

Software starts a transmit or receive step by pulsing a trigger. The block passes the trigger on to the engine as a go pulse, unless the receive buffer is full and unread. In that case it refuses the step and records an overrun. Recovery takes two steps: first write 1 to the overrun flag, then drain the buffer with two reads. The block never requests DMA service.

Top module: `i2cSlaveStatus`

## Requirements
- R1: `status` resets to 0 and, after a cycle with an event pulse, holds that event's code: start=0, stop=1, byte sent=2, byte received=3, ACK/NAK sent=4, ACK received=5, NAK received=6 (7 is never produced). With no event pulse, `status` keeps its value.
- R2: When several event pulses arrive in one cycle, the event with the numerically largest code is recorded.
- R3: `opDone` sets `cmplFlag` on the next edge. Writing with `flagWr`=1 and `flagWrCmpl`=1 clears it. Writing 0 to that bit leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R4: `irq` is a level equal to (`cmplFlag` AND complete-enable) OR (`errFlag` AND error-enable). It is visible in the same cycle the flag first reads 1.
- R5: Both enables reset to 0 and are loaded from `cfgCmplEn`/`cfgErrEn` when `cfgWr`=1. While the error enable is 0, `errFlag` never raises `irq`.
- R6: The receive buffer holds up to DEPTH (default 2) bytes in arrival order. `evRxDone` pushes `rxByte`. `rdPop` removes the oldest byte. `rxCount` reports the fill level. `rdData` shows the oldest held byte.
- R7: A `rdPop` on an empty buffer changes nothing, and `rdData` keeps showing the last byte read (0 after reset).
- R8: An overrun occurs when `trigTx` or `trigRx` is pulsed while the buffer is full and not popped in that cycle. On an overrun, `errFlag` is set on the next edge. Writing 1 via `flagWrErr` clears it, and a set wins over a clear.
- R9: An overrunning trigger produces no `txGo`/`rxGo` pulse. Otherwise each trigger is passed on combinationally as its go pulse. A received byte that arrives while the buffer is full, with no pop in that cycle, is dropped.
- R10: Recovery after an overrun (clear `errFlag`, then two pops) leaves `errFlag`=0 and `rxCount`=0, and a following trigger is passed on.
- R11: `dmaReq` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evStart | input | 1 | Engine pulse: start condition seen |
| evStop | input | 1 | Engine pulse: stop condition seen |
| evTxDone | input | 1 | Engine pulse: byte transmitted |
| evRxDone | input | 1 | Engine pulse: byte received, `rxByte` valid |
| evAckSent | input | 1 | Engine pulse: ACK or NAK driven |
| evAckRecv | input | 1 | Engine pulse: ACK received |
| evNakRecv | input | 1 | Engine pulse: NAK received |
| rxByte | input | DATA_W | Received byte |
| opDone | input | 1 | Engine pulse: triggered operation finished |
| trigTx | input | 1 | Software transmit trigger |
| trigRx | input | 1 | Software receive trigger |
| rdPop | input | 1 | CPU read of the receive data register |
| cfgWr | input | 1 | Load both enables |
| cfgCmplEn | input | 1 | Complete-interrupt enable value |
| cfgErrEn | input | 1 | Error-interrupt enable value |
| flagWr | input | 1 | Flag register write strobe |
| flagWrCmpl | input | 1 | Write-1-to-clear bit for `cmplFlag` |
| flagWrErr | input | 1 | Write-1-to-clear bit for `errFlag` |
| txGo | output | 1 | Transmit step passed to engine |
| rxGo | output | 1 | Receive step passed to engine |
| rdData | output | DATA_W | Receive data register value |
| rxCount | output | CNT_W | Bytes held in the receive buffer |
| status | output | 3 | Code of the last event |
| cmplFlag | output | 1 | Operation-complete flag |
| errFlag | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request level |
| dmaReq | output | 1 | DMA request, always 0 |

## Verification
Event codes are first applied one at a time, which exposes encoding mistakes. They are then applied in simultaneous pairs, which separates a largest-code rule from a first-match or OR-merge rule. The buffer is exercised in four ways: single pushes and pops, pops of an empty buffer, pushes into a full buffer, and triggers at full occupancy with and without a pop in the same cycle. Together these separate the true overrun condition from off-by-one fill checks and from overruns that fire even though a pop is under way. Flags are cycled through set, write-0, write-1 and set-with-clear, with each enable on and off, so the interrupt level is checked against every flag and enable combination.

// File: rtl/i2cStatusPkg.sv
package i2cStatusPkg;

  typedef enum logic [2:0] {
    EV_START    = 3'd0,
    EV_STOP     = 3'd1,
    EV_TXEND    = 3'd2,
    EV_RXEND    = 3'd3,
    EV_ACKSENT  = 3'd4,
    EV_ACKRECV  = 3'd5,
    EV_NAKRECV  = 3'd6,
    EV_RESERVED = 3'd7
  } evCodeT;

  localparam int NUM_EVENTS = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic       push;
    logic       pop;
    logic       stUpd;
    logic [2:0] stCode;
    logic       setCmpl;
    logic       clrCmpl;
    logic       setErr;
    logic       clrErr;
    logic       cfgLoad;
  } strobeT;

endpackage

// File: rtl/i2cStatusCtrl.sv
module i2cStatusCtrl
  import i2cStatusPkg::*;
#(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [NUM_EVENTS-1:0] evVec,
  input  logic                  opDone,
  input  logic                  trigTx,
  input  logic                  trigRx,
  input  logic                  rdPop,
  input  logic                  cfgWr,
  input  logic                  flagWr,
  input  logic                  flagWrCmpl,
  input  logic                  flagWrErr,
  input  logic [CNT_W-1:0]      rxCount,
  output strobeT                strobe,
  output logic                  txGo,
  output logic                  rxGo
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic       bufFull;
  logic       bufBlocked;
  logic       overrun;
  logic [2:0] winCode;

  // Largest set code wins: later iterations override earlier ones
  always_comb begin
    winCode = 3'd0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (evVec[i]) winCode = 3'(i);
    end
  end

  assign bufFull    = (rxCount == FULL_LVL);
  assign bufBlocked = bufFull & ~rdPop;
  assign overrun    = (trigTx | trigRx) & bufBlocked;

  assign txGo = trigTx & ~bufBlocked;
  assign rxGo = trigRx & ~bufBlocked;

  always_comb begin
    strobe         = '0;
    strobe.push    = evVec[EV_RXEND] & ~bufBlocked;
    strobe.pop     = rdPop & (rxCount != '0);
    strobe.stUpd   = |evVec;
    strobe.stCode  = winCode;
    strobe.setCmpl = opDone;
    strobe.clrCmpl = flagWr & flagWrCmpl;
    strobe.setErr  = overrun;
    strobe.clrErr  = flagWr & flagWrErr;
    strobe.cfgLoad = cfgWr;
  end

endmodule

// File: rtl/i2cStatusData.sv
module i2cStatusData
  import i2cStatusPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              cfgCmplEn,
  input  logic              cfgErrEn,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  rxCount,
  output logic [2:0]        status,
  output logic              cmplFlag,
  output logic              errFlag,
  output logic              cmplEn,
  output logic              errEn
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] lastRd;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slot[g] <= '0;
      else if (strobe.push && wrPtr == PTR_W'(g)) slot[g] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rxCount <= '0;
      lastRd  <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop) begin
        rdPtr  <= nextPtr(rdPtr);
        lastRd <= slot[rdPtr];
      end
      case ({strobe.push, strobe.pop})
        2'b10:   rxCount <= rxCount + 1'b1;
        2'b01:   rxCount <= rxCount - 1'b1;
        default: rxCount <= rxCount;
      endcase
    end
  end

  assign rdData = (rxCount != '0) ? slot[rdPtr] : lastRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status   <= EV_START;
      cmplFlag <= 1'b0;
      errFlag  <= 1'b0;
      cmplEn   <= 1'b0;
      errEn    <= 1'b0;
    end else begin
      if (strobe.stUpd) status <= strobe.stCode;
      if (strobe.setCmpl)      cmplFlag <= 1'b1;
      else if (strobe.clrCmpl) cmplFlag <= 1'b0;
      if (strobe.setErr)       errFlag <= 1'b1;
      else if (strobe.clrErr)  errFlag <= 1'b0;
      if (strobe.cfgLoad) begin
        cmplEn <= cfgCmplEn;
        errEn  <= cfgErrEn;
      end
    end
  end

endmodule

// File: rtl/i2cSlaveStatus.sv
module i2cSlaveStatus
  import i2cStatusPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evTxDone,
  input  logic              evRxDone,
  input  logic              evAckSent,
  input  logic              evAckRecv,
  input  logic              evNakRecv,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              opDone,
  input  logic              trigTx,
  input  logic              trigRx,
  input  logic              rdPop,
  input  logic              cfgWr,
  input  logic              cfgCmplEn,
  input  logic              cfgErrEn,
  input  logic              flagWr,
  input  logic              flagWrCmpl,
  input  logic              flagWrErr,
  output logic              txGo,
  output logic              rxGo,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  rxCount,
  output logic [2:0]        status,
  output logic              cmplFlag,
  output logic              errFlag,
  output logic              irq,
  output logic              dmaReq
);

  strobeT                strobe;
  logic [NUM_EVENTS-1:0] evVec;
  logic                  cmplEn;
  logic                  errEn;

  // Bit index equals the event's status code
  assign evVec = {evNakRecv, evAckRecv, evAckSent, evRxDone,
                  evTxDone, evStop, evStart};

  i2cStatusCtrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .evVec      (evVec),
    .opDone     (opDone),
    .trigTx     (trigTx),
    .trigRx     (trigRx),
    .rdPop      (rdPop),
    .cfgWr      (cfgWr),
    .flagWr     (flagWr),
    .flagWrCmpl (flagWrCmpl),
    .flagWrErr  (flagWrErr),
    .rxCount    (rxCount),
    .strobe     (strobe),
    .txGo       (txGo),
    .rxGo       (rxGo)
  );

  i2cStatusData #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rxByte    (rxByte),
    .cfgCmplEn (cfgCmplEn),
    .cfgErrEn  (cfgErrEn),
    .rdData    (rdData),
    .rxCount   (rxCount),
    .status    (status),
    .cmplFlag  (cmplFlag),
    .errFlag   (errFlag),
    .cmplEn    (cmplEn),
    .errEn     (errEn)
  );

  assign irq    = (cmplFlag & cmplEn) | (errFlag & errEn);
  assign dmaReq = 1'b0;

endmodule

// File: rtl/i2cStatusChecker.sv
module i2cStatusChecker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              evStart,
  input logic              evStop,
  input logic              evTxDone,
  input logic              evRxDone,
  input logic              evAckSent,
  input logic              evAckRecv,
  input logic              evNakRecv,
  input logic              opDone,
  input logic              trigTx,
  input logic              trigRx,
  input logic              rdPop,
  input logic              txGo,
  input logic              rxGo,
  input logic [DATA_W-1:0] rdData,
  input logic [CNT_W-1:0]  rxCount,
  input logic [2:0]        status,
  input logic              cmplFlag,
  input logic              errFlag,
  input logic              irq
);

  logic anyEv;
  assign anyEv = evStart | evStop | evTxDone | evRxDone |
                 evAckSent | evAckRecv | evNakRecv;

  // R1
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyEv |=> $stable(status));

  // R1
  status_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    status != 3'd7);

  // R3
  cmpl_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> cmplFlag);

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmplFlag && !errFlag) |-> !irq);

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && rxCount == '0 && !evRxDone) |=> (rxCount == '0 && $stable(rdData)));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((trigTx || trigRx) && rxCount == CNT_W'(DEPTH) && !rdPop) |=> errFlag);

  // R9
  no_go_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == CNT_W'(DEPTH) && !rdPop) |-> (!txGo && !rxGo));

  // R9
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == CNT_W'(DEPTH) && !rdPop) |=> rxCount == CNT_W'(DEPTH));

endmodule

bind i2cSlaveStatus i2cStatusChecker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
  .evTxDone(evTxDone), .evRxDone(evRxDone), .evAckSent(evAckSent),
  .evAckRecv(evAckRecv), .evNakRecv(evNakRecv), .opDone(opDone),
  .trigTx(trigTx), .trigRx(trigRx), .rdPop(rdPop), .txGo(txGo), .rxGo(rxGo),
  .rdData(rdData), .rxCount(rxCount), .status(status), .cmplFlag(cmplFlag),
  .errFlag(errFlag), .irq(irq)
);

// File: tb/test_i2cSlaveStatus.sv
module test_i2cSlaveStatus;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 0, evStop = 0, evTxDone = 0, evRxDone = 0;
  logic evAckSent = 0, evAckRecv = 0, evNakRecv = 0;
  logic [DATA_W-1:0] rxByte = '0;
  logic opDone = 0, trigTx = 0, trigRx = 0, rdPop = 0;
  logic cfgWr = 0, cfgCmplEn = 0, cfgErrEn = 0;
  logic flagWr = 0, flagWrCmpl = 0, flagWrErr = 0;
  logic txGo, rxGo, cmplFlag, errFlag, irq, dmaReq;
  logic [DATA_W-1:0] rdData;
  logic [CNT_W-1:0]  rxCount;
  logic [2:0]        status;

  always #5 clk = ~clk;

  i2cSlaveStatus #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_i2cSlaveStatus (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evTxDone(evTxDone), .evRxDone(evRxDone), .evAckSent(evAckSent),
    .evAckRecv(evAckRecv), .evNakRecv(evNakRecv), .rxByte(rxByte),
    .opDone(opDone), .trigTx(trigTx), .trigRx(trigRx), .rdPop(rdPop),
    .cfgWr(cfgWr), .cfgCmplEn(cfgCmplEn), .cfgErrEn(cfgErrEn),
    .flagWr(flagWr), .flagWrCmpl(flagWrCmpl), .flagWrErr(flagWrErr),
    .txGo(txGo), .rxGo(rxGo), .rdData(rdData), .rxCount(rxCount),
    .status(status), .cmplFlag(cmplFlag), .errFlag(errFlag),
    .irq(irq), .dmaReq(dmaReq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  int        mStatus = 0;
  bit        mCmpl = 0, mErr = 0, mCEn = 0, mEEn = 0;
  logic [7:0] q[$];
  logic [7:0] mLast = 8'h00;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit blocked();
    return (q.size() == DEPTH) && !rdPop;
  endfunction

  task automatic compareAll();
    int expRd;
    int expIrq;
    expRd  = (q.size() > 0) ? int'(q[0]) : int'(mLast);
    expIrq = int'((mCmpl && mCEn) || (mErr && mEEn));
    check(int'(status) == mStatus, "R1 status", int'(status), mStatus);
    check(int'(cmplFlag) == int'(mCmpl), "R3 cmplFlag", int'(cmplFlag), int'(mCmpl));
    check(int'(errFlag) == int'(mErr), "R8 errFlag", int'(errFlag), int'(mErr));
    check(int'(irq) == expIrq, "R4 irq", int'(irq), expIrq);
    check(int'(rxCount) == q.size(), "R6 rxCount", int'(rxCount), q.size());
    check(int'(rdData) == expRd, "R7 rdData", int'(rdData), expRd);
    check(int'(txGo) == int'(trigTx && !blocked()), "R9 txGo", int'(txGo), int'(trigTx && !blocked()));
    check(int'(rxGo) == int'(trigRx && !blocked()), "R9 rxGo", int'(rxGo), int'(trigRx && !blocked()));
    check(dmaReq == 1'b0, "R11 dmaReq", int'(dmaReq), 0);
  endtask

  task automatic modelEdge();
    bit blk;
    bit didPop;
    blk = blocked();
    didPop = 0;
    if (evStart)   mStatus = 0;
    if (evStop)    mStatus = 1;
    if (evTxDone)  mStatus = 2;
    if (evRxDone)  mStatus = 3;
    if (evAckSent) mStatus = 4;
    if (evAckRecv) mStatus = 5;
    if (evNakRecv) mStatus = 6;
    if (opDone) mCmpl = 1;
    else if (flagWr && flagWrCmpl) mCmpl = 0;
    if ((trigTx || trigRx) && blk) mErr = 1;
    else if (flagWr && flagWrErr) mErr = 0;
    if (cfgWr) begin
      mCEn = cfgCmplEn;
      mEEn = cfgErrEn;
    end
    if (rdPop && q.size() > 0) begin
      mLast = q.pop_front();
      didPop = 1;
    end
    if (evRxDone && (!blk || didPop)) q.push_back(rxByte);
  endtask

  task automatic idle();
    {evStart, evStop, evTxDone, evRxDone, evAckSent, evAckRecv, evNakRecv} = '0;
    {opDone, trigTx, trigRx, rdPop, cfgWr, cfgCmplEn, cfgErrEn} = '0;
    {flagWr, flagWrCmpl, flagWrErr} = '0;
    rxByte = '0;
  endtask

  task automatic step();
    #2;
    compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    idle();
  endtask

  task automatic pushByte(input logic [7:0] b);
    evRxDone = 1; rxByte = b; step();
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    #2;
    // R1 reset state
    check(status == 3'd0, "R1 reset status", int'(status), 0);
    check(!cmplFlag && !errFlag && !irq, "R4 reset flags/irq", int'({cmplFlag, errFlag, irq}), 0);
    check(rxCount == '0, "R6 reset count", int'(rxCount), 0);
    @(negedge clk);
    rstN = 1'b1;
    step();

    // R1 each event alone
    evStop = 1; step();
    evTxDone = 1; step();
    evAckSent = 1; step();
    evAckRecv = 1; step();
    evNakRecv = 1; step();
    evStart = 1; step();
    pushByte(8'hA1);
    step();

    // R2 simultaneous events
    evStart = 1; evNakRecv = 1; step();
    #2 check(status == 3'd6, "R2 start+nak", int'(status), 6);
    evStop = 1; evTxDone = 1; step();
    #2 check(status == 3'd2, "R2 stop+txend", int'(status), 2);
    evAckSent = 1; evStart = 1; evStop = 1; step();

    // R7 pops, including empty pops
    rdPop = 1; step();
    rdPop = 1; step();
    #2 check(rdData == 8'hA1, "R7 empty keeps last", int'(rdData), 8'hA1);
    rdPop = 1; evRxDone = 1; rxByte = 8'h3C; step();   // pop empty with push

    // R3 complete flag
    opDone = 1; step();
    flagWr = 1; flagWrCmpl = 0; flagWrErr = 0; step();   // write 0: no effect
    cfgWr = 1; cfgCmplEn = 1; step();
    #2 check(irq == 1'b1, "R4 irq from cmpl", int'(irq), 1);
    flagWr = 1; flagWrCmpl = 1; step();
    opDone = 1; flagWr = 1; flagWrCmpl = 1; step();       // set wins
    flagWr = 1; flagWrCmpl = 1; step();
    cfgWr = 1; cfgCmplEn = 0; step();

    // R6 order, then fill
    rdPop = 1; step();
    pushByte(8'h11);
    pushByte(8'h22);
    pushByte(8'h33);                 // R9 dropped while full
    trigTx = 1; rdPop = 1; step();   // pop in same cycle: passes, no overrun
    pushByte(8'h44);
    // R5 error enable 0: overrun sets flag, no irq
    trigRx = 1; step();
    #2 check(errFlag && !irq, "R5 err without irq", int'({errFlag, irq}), 2);
    cfgWr = 1; cfgErrEn = 1; step();
    #2 check(irq == 1'b1, "R4 irq from err", int'(irq), 1);
    trigTx = 1; evRxDone = 1; rxByte = 8'h55; step();  // overrun again, push dropped
    // R10 recovery: clear then two reads
    flagWr = 1; flagWrErr = 1; step();
    rdPop = 1; step();
    rdPop = 1; step();
    #2 check(!errFlag && rxCount == '0, "R10 recovered", int'({errFlag, rxCount}), 0);
    trigTx = 1; step();
    // overrun set wins over clear
    pushByte(8'h66);
    pushByte(8'h77);
    trigTx = 1; flagWr = 1; flagWrErr = 1; step();
    for (int i = 0; i < 3; i++) begin
      rdPop = 1; step();
    end
    flagWr = 1; flagWrErr = 1; step();
    step();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule